// File: doc/BRIEF.md
# Keypad Group Select and Press Interrupt Register

This block is a byte-wide register that gives software a view of an eight-button pad arranged as two groups of four lines. Software writes a two-bit group select. The low nibble of the register then shows the chosen group. A line reads 0 while its button is pressed.

Whenever a visible line falls from 1 to 0, the block pulses an interrupt request for one cycle. A fall caused by a button change is reported at once. A fall caused by a register write is reported a fixed number of cycles later.

The register is re-evaluated on every clock, so the nibble follows the button inputs without any software action. Debouncing is done upstream, and interrupt routing is done downstream.

Top module: `keypad_scan_reg`

## Requirements
- R1: A write (wr_en high at a rising edge) replaces register bits 5:4 with wr_data[5:4]. All other bits of wr_data are ignored, and bits 5:4 hold their value when no write occurs.
- R2: Register bits 7:6 always read as 1.
- R3: With select 2'b10, bits 3:0 show btn_raw[3:0].
- R4: With select 2'b01, bits 3:0 show btn_raw[7:4].
- R5: With select 2'b00, bits 3:0 show btn_raw[3:0] & btn_raw[7:4].
- R6: With select 2'b11, bits 3:0 read 4'hF.
- R7: If any of bits 3:0 goes from 1 to 0 at an edge with no write, irq_pulse is high for the cycle after that edge. This is the same cycle in which the new nibble appears on rd_data.
- R8: If any of bits 3:0 goes from 1 to 0 at an edge where a write is applied, irq_pulse stays low after that edge and is high for one cycle, 4 edges later.
- R9: A new write-caused fall during a pending delay neither restarts nor extends the delay, and adds no extra pulse.
- R10: A 0-to-1 change of a nibble bit raises no request.
- R11: After reset, rd_data reads 8'hFF (select 2'b11), no delay is pending, and irq_pulse is 0.
- R12: rd_data[3:0] is updated from btn_raw on every edge, one cycle after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| btn_raw | input | 8 | Active-low button lines, two groups of four |
| rd_data | output | 8 | Register read value |
| irq_pulse | output | 1 | One-cycle keypad interrupt request |

## Verification
A corrupted select register shows at once on rd_data[5:4]. From the next edge it also shows as the wrong group, or the wrong combination of groups, in the low nibble. A faulty edge detector shows as a missing or spurious irq_pulse in the cycle right after the nibble changes. A faulty delay counter shows as a pulse one or more cycles early or late after a write, or as an extra pulse when write-caused falls overlap. The bench compares rd_data and irq_pulse against its own model after every edge, so any such error is caught within the same cycle.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int GROUP_W = 4;
  localparam int SEL_W   = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_BOTH = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_NONE = 2'b11
  } kp_sel_e;
endpackage

// File: rtl/kp_view_mux.sv
module kp_view_mux
  import kp_pkg::*;
#(
  parameter int GW = GROUP_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [2*GW-1:0]  btn,
  output logic [GW-1:0]    view
);
  logic [GW-1:0] grp_lo;
  logic [GW-1:0] grp_hi;
  assign grp_lo = btn[GW-1:0];
  assign grp_hi = btn[2*GW-1:GW];

  always_comb begin
    case (kp_sel_e'(sel))
      SEL_LOW:  view = grp_lo;
      SEL_HIGH: view = grp_hi;
      SEL_BOTH: view = grp_lo & grp_hi;
      default:  view = '1;
    endcase
  end
endmodule

// File: rtl/kp_fall_detect.sv
module kp_fall_detect #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] nxt,
  output logic          fall
);
  logic [GW-1:0] per_line;
  genvar i;
  generate
    for (i = 0; i < GW; i++) begin : g_line
      assign per_line[i] = cur[i] & ~nxt[i];
    end
  endgenerate
  assign fall = |per_line;
endmodule

// File: rtl/kp_irq_timer.sv
module kp_irq_timer #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_now,
  input  logic fall_late,
  output logic irq
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end else if (fall_late) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD;
    end
    irq_d = fall_now | (cnt_q == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/keypad_scan_reg.sv
module keypad_scan_reg
  import kp_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] btn_raw,
  output logic [7:0] rd_data,
  output logic       irq_pulse
);
  localparam int SEL_LSB = GROUP_W;
  localparam int SEL_MSB = GROUP_W + SEL_W - 1;

  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [GROUP_W-1:0] nib_q, nib_d;
  logic               fall;

  always_comb begin
    sel_d = wr_en ? wr_data[SEL_MSB:SEL_LSB] : sel_q;
  end

  kp_view_mux #(.GW(GROUP_W)) u_mux (
    .sel  (sel_d),
    .btn  (btn_raw),
    .view (nib_d)
  );

  kp_fall_detect #(.GW(GROUP_W)) u_fall (
    .cur  (nib_q),
    .nxt  (nib_d),
    .fall (fall)
  );

  kp_irq_timer #(.DELAY(DELAY)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_now  (fall & ~wr_en),
    .fall_late (fall & wr_en),
    .irq       (irq_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
      nib_q <= '1;
    end else begin
      if (wr_en) sel_q <= sel_d;
      nib_q <= nib_d;
    end
  end

  assign rd_data = {2'b11, sel_q, nib_q};
endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_pulse
);
  AST_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b11); // R2
  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[5:4] == $past(wr_data[5:4])); // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[5:4])); // R1
  AST_NONE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:4] == 2'b11 |-> rd_data[3:0] == 4'hF); // R6
  AST_BTN_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && (($past(rd_data[3:0]) & ~rd_data[3:0]) != 4'h0)) |-> irq_pulse); // R7
endmodule

bind keypad_scan_reg kp_scan_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .irq_pulse (irq_pulse)
);

// File: tb/keypad_scan_reg_bench.sv
module keypad_scan_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] btn_raw;
  logic [7:0] rd_data;
  logic       irq_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] m_sel;
  logic [3:0] m_nib;
  int         m_pend;
  logic       m_irq;

  keypad_scan_reg u_keypad_scan_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .btn_raw(btn_raw), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] view_of(input logic [1:0] s, input logic [7:0] b);
    case (s)
      2'b10:   return b[3:0];
      2'b01:   return b[7:4];
      2'b00:   return b[3:0] & b[7:4];
      default: return 4'hF;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [7:0] exp_rd;
    exp_rd = {2'b11, m_sel, m_nib};
    checks++;
    if (rd_data !== exp_rd || irq_pulse !== m_irq) begin
      failures++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               tag, rd_data, irq_pulse, exp_rd, m_irq);
    end
  endtask

  // called at a negedge: drive, advance model, wait edge, check at next negedge
  task automatic step(input logic wr, input logic [7:0] d, input logic [7:0] b, input string tag);
    logic [1:0] ns;
    logic [3:0] nn;
    logic       fall;
    wr_en = wr; wr_data = d; btn_raw = b;
    ns = wr ? d[5:4] : m_sel;
    nn = view_of(ns, b);
    fall = |(m_nib & ~nn);
    m_irq = (fall && !wr) || (m_pend == 1);
    if (m_pend != 0) m_pend--;
    else if (fall && wr) m_pend = DLY;
    m_sel = ns; m_nib = nn;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; btn_raw = 8'hFF;
    m_sel = 2'b11; m_nib = 4'hF; m_pend = 0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset");
    rst_n = 1'b1;
    step(1'b0, 8'h00, 8'h00, "R6 idle select shows F");
    step(1'b0, 8'h00, 8'hFF, "R11 no irq from forced view");
    step(1'b1, 8'hEF, 8'hFF, "R1 R3 select low group");
    step(1'b0, 8'h00, 8'hFA, "R7 button fall immediate irq");
    step(1'b0, 8'h00, 8'hFA, "R7 single pulse");
    step(1'b0, 8'h00, 8'hFF, "R10 rise no irq");
    step(1'b1, 8'h1F, 8'h5F, "R4 R8 write fall delayed, other bits ignored R1");
    step(1'b0, 8'h00, 8'h5F, "R8 wait 1");
    step(1'b0, 8'h00, 8'h5F, "R8 wait 2");
    step(1'b0, 8'h00, 8'h5F, "R8 wait 3");
    step(1'b0, 8'h00, 8'h5F, "R8 pulse after 4");
    step(1'b0, 8'h00, 8'h5F, "R8 pulse ends");
    step(1'b1, 8'h00, 8'h3C, "R5 both groups ANDed, write fall");
    step(1'b1, 8'h20, 8'h3C, "R9 pending not restarted");
    step(1'b1, 8'h10, 8'h33, "R9 second write fall absorbed");
    step(1'b0, 8'h00, 8'h33, "R9 wait");
    step(1'b0, 8'h00, 8'h33, "R9 single delayed pulse");
    step(1'b0, 8'h00, 8'h33, "R9 no extra pulse");
    step(1'b1, 8'h30, 8'h00, "R6 forced F with buttons low");
    step(1'b0, 8'h00, 8'h00, "R6 hold");
    step(1'b1, 8'h20, 8'hFF, "R3 select low");
    for (int i = 0; i < 8; i++)
      step(1'b0, 8'h00, 8'(~(8'h1 << i)), "R12 tracking");
    for (int i = 0; i < 2000; i++) begin
      logic       w;
      logic [7:0] d, b;
      w = ($urandom % 4) == 0;
      d = 8'($urandom);
      b = ($urandom % 3 == 0) ? 8'($urandom) : btn_raw;
      step(w, d, b, "R12 random R7 R8 R9");
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule